// File: doc/BRIEF.md
# PLL Fast-Acquisition Sequencer and Lock Indicator

This block sits beside the phase/frequency comparator of a frequency synthesizer. It decides when the loop runs in fast-acquisition ("pull-in") mode and which speed-up aids are active during that time. The aids are a loop-filter saturation reset, a doubled charge-pump current and a halved damping resistance. Software arms acquisition by writing a start flag with the divider word. Acquisition then ends in one of two ways: software clears the flag, or, if auto-termination was chosen with the reference word, the loop reports lock.

A small digital lock detector watches the reference-side and VCO-side comparison pulses. It declares lock after a run of consecutive well-aligned comparison cycles, and drops it on any misaligned one. The lock state drives a single output pin. In test mode the same pin becomes a multiplexer for internal signals. A standby input clears the lock detector and floats the charge pump, while every programmed flag is kept.

Top module: `pullin_lock_ctrl`

## Requirements
- R1: A cycle with `wr_div_word` high loads `f_flag` into the acquisition state on the next clock edge: 1 enters pull-in and 0 leaves it.
- R2: A `wr_div_word` write with `f_flag` = 1 clears the lock detector, so `lock_out` (normal mode) is low in the following cycle.
- R3: With `e_flag` = 1 captured by `wr_ref_word`, pull-in ends on the clock edge after lock is indicated. With `e_flag` = 0, pull-in continues while locked, until `f_flag` = 0 is written.
- R4: During pull-in, `sat_reset` follows the stored `s_flag` and `cp_double` follows the stored `i_flag`. Both flags are captured on `wr_ref_word`.
- R5: During pull-in, `damp_half` is high when either stored flag (s or i) is 1. All three aids are low whenever pull-in is off, including the very cycle in which it ends.
- R6: A comparison is a hit when the partner pulse of the other side arrives in the same cycle or within WIN_CYCLES cycles after the first one. Lock is indicated once LOCK_HITS consecutive hits have been counted, and not before.
- R7: A miss clears lock on the next edge. A miss is either no partner pulse within WIN_CYCLES cycles, or a second pulse from the same side before any partner.
- R8: With `test_mode` low, `lock_out` is high when locked and low when unlocked.
- R9: With `test_mode` high, stored selector bit `test_sel[2]` = 1 routes `div_err` to `lock_out`. Otherwise the selector bits {`test_sel[1]`,`test_sel[0]`} route: 00 to `ref_pulse`, 01 to `vco_pulse`, 10 to `mod_pulse`, and 11 to the pull-in state.
- R10: `wr_test_word` stores `test_sel` only while `test_mode` is high. While `test_mode` is low, the stored selector is held at 000.
- R11: While `standby` is high, `cp_hiz` is high and the lock detector is held cleared. The programmed flags are kept.
- R12: After reset, pull-in is off, all aids are low, lock is clear and the stored selector is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Power-save request |
| wr_ref_word | input | 1 | Strobe capturing s/i/e flags |
| s_flag | input | 1 | Saturation-reset aid enable |
| i_flag | input | 1 | Current-double aid enable |
| e_flag | input | 1 | End acquisition automatically on lock |
| wr_div_word | input | 1 | Strobe capturing the start flag |
| f_flag | input | 1 | Acquisition start (1) / stop (0) |
| test_mode | input | 1 | Test mode active |
| wr_test_word | input | 1 | Strobe capturing the test selector |
| test_sel | input | 3 | Test selector, bit 2 picks div_err |
| ref_pulse | input | 1 | Reference-side comparison pulse |
| vco_pulse | input | 1 | VCO-side comparison pulse |
| mod_pulse | input | 1 | Prescaler modulus control (test view) |
| div_err | input | 1 | Divider error flag (test view) |
| sat_reset | output | 1 | Loop-filter saturation reset |
| cp_double | output | 1 | Charge-pump current double |
| damp_half | output | 1 | Damping-resistance halving switch |
| cp_hiz | output | 1 | Charge-pump tristate |
| lock_out | output | 1 | Lock indicator / test mux output |

## Verification
Two functions can act in the same cycle. The lock detector's final hit can raise lock while pull-in is armed with auto-termination. Separately, a write of the start flag can land while lock is already high. The bench provokes the first by sending exactly LOCK_HITS aligned pulse pairs after arming with e = 1. It then checks that the aids are still on in the cycle lock first appears and are gone in the next. It provokes the second by re-arming while locked, and judges that lock is cleared and not kept alive by the auto-exit path, so pull-in stays on.

// File: rtl/pullin_lock_pkg.sv
package pullin_lock_pkg;

  // Acquisition state update: a start/stop write wins over auto-termination.
  function automatic logic next_acq(logic cur, logic wr, logic start,
                                    logic auto_end, logic locked);
    if (wr) return start;
    return cur & ~(auto_end & locked);
  endfunction

  // Output pin routing; sel[2] overrides, sel[1:0] picks a live signal.
  function automatic logic pin_route(logic tmode, logic [2:0] sel,
                                     logic locked, logic rck, logic vck,
                                     logic modv, logic acq, logic derr);
    if (!tmode) return locked;
    if (sel[2]) return derr;
    case (sel[1:0])
      2'b00:   return rck;
      2'b01:   return vck;
      2'b10:   return modv;
      default: return acq;
    endcase
  endfunction

endpackage

// File: rtl/lock_window_det.sv
module lock_window_det #(
  parameter int WIN_CYCLES = 3,
  parameter int LOCK_HITS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic ref_pulse,
  input  logic vco_pulse,
  output logic hit,
  output logic miss,
  output logic locked
);
  localparam int WW = (WIN_CYCLES < 2) ? 1 : $clog2(WIN_CYCLES);
  localparam int CW = $clog2(LOCK_HITS + 1);
  localparam logic [WW-1:0] WLAST = WW'(WIN_CYCLES - 1);
  localparam logic [CW-1:0] CFULL = CW'(LOCK_HITS);

  logic          pend_r, pend_v;
  logic [WW-1:0] wcnt;
  logic [CW-1:0] good;
  logic          dup, timeout;

  always_comb begin
    hit     = (ref_pulse & vco_pulse) | (ref_pulse & pend_v) | (vco_pulse & pend_r);
    dup     = (ref_pulse & ~vco_pulse & pend_r) | (vco_pulse & ~ref_pulse & pend_v);
    timeout = (pend_r | pend_v) & ~ref_pulse & ~vco_pulse & (wcnt == WLAST);
    miss    = dup | timeout;
    locked  = (good == CFULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_r <= 1'b0;
      pend_v <= 1'b0;
      wcnt   <= '0;
      good   <= '0;
    end else if (clear) begin
      pend_r <= 1'b0;
      pend_v <= 1'b0;
      wcnt   <= '0;
      good   <= '0;
    end else begin
      if (hit) begin
        pend_r <= 1'b0;
        pend_v <= 1'b0;
        wcnt   <= '0;
      end else if (ref_pulse) begin
        pend_r <= 1'b1;
        pend_v <= 1'b0;
        wcnt   <= '0;
      end else if (vco_pulse) begin
        pend_v <= 1'b1;
        pend_r <= 1'b0;
        wcnt   <= '0;
      end else if (timeout) begin
        pend_r <= 1'b0;
        pend_v <= 1'b0;
        wcnt   <= '0;
      end else if (pend_r | pend_v) begin
        wcnt <= wcnt + 1'b1;
      end
      if (miss) good <= '0;
      else if (hit && !locked) good <= good + 1'b1;
    end
  end
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import pullin_lock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ref_word,
  input  logic s_flag,
  input  logic i_flag,
  input  logic e_flag,
  input  logic wr_div_word,
  input  logic f_flag,
  input  logic locked,
  output logic acq_on,
  output logic e_mode,
  output logic clr_lock,
  output logic sat_reset,
  output logic cp_double,
  output logic damp_half
);
  logic s_q, i_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q    <= 1'b0;
      i_q    <= 1'b0;
      e_mode <= 1'b0;
      acq_on <= 1'b0;
    end else begin
      if (wr_ref_word) begin
        s_q    <= s_flag;
        i_q    <= i_flag;
        e_mode <= e_flag;
      end
      acq_on <= next_acq(acq_on, wr_div_word, f_flag, e_mode, locked);
    end
  end

  always_comb begin
    clr_lock  = wr_div_word & f_flag;
    sat_reset = acq_on & s_q;
    cp_double = acq_on & i_q;
    damp_half = acq_on & (s_q | i_q);
  end
endmodule

// File: rtl/lock_pin_mux.sv
module lock_pin_mux
  import pullin_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       test_mode,
  input  logic       wr_test_word,
  input  logic [2:0] test_sel,
  input  logic       locked,
  input  logic       ref_pulse,
  input  logic       vco_pulse,
  input  logic       mod_pulse,
  input  logic       acq_on,
  input  logic       div_err,
  output logic       lock_out
);
  logic [2:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            sel_q <= '0;
    else if (!test_mode)   sel_q <= '0;
    else if (wr_test_word) sel_q <= test_sel;
  end

  always_comb
    lock_out = pin_route(test_mode, sel_q, locked, ref_pulse, vco_pulse,
                         mod_pulse, acq_on, div_err);
endmodule

// File: rtl/pullin_lock_ctrl.sv
module pullin_lock_ctrl #(
  parameter int WIN_CYCLES = 3,
  parameter int LOCK_HITS  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       standby,
  input  logic       wr_ref_word,
  input  logic       s_flag,
  input  logic       i_flag,
  input  logic       e_flag,
  input  logic       wr_div_word,
  input  logic       f_flag,
  input  logic       test_mode,
  input  logic       wr_test_word,
  input  logic [2:0] test_sel,
  input  logic       ref_pulse,
  input  logic       vco_pulse,
  input  logic       mod_pulse,
  input  logic       div_err,
  output logic       sat_reset,
  output logic       cp_double,
  output logic       damp_half,
  output logic       cp_hiz,
  output logic       lock_out
);
  logic locked, lock_hit, lock_miss, acq_on, e_mode, clr_lock, det_clear;

  assign det_clear = standby | clr_lock;
  assign cp_hiz    = standby;

  lock_window_det #(.WIN_CYCLES(WIN_CYCLES), .LOCK_HITS(LOCK_HITS)) u_det (
    .clk(clk), .rst_n(rst_n), .clear(det_clear),
    .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
    .hit(lock_hit), .miss(lock_miss), .locked(locked)
  );

  acq_sequencer u_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_ref_word(wr_ref_word), .s_flag(s_flag), .i_flag(i_flag), .e_flag(e_flag),
    .wr_div_word(wr_div_word), .f_flag(f_flag), .locked(locked),
    .acq_on(acq_on), .e_mode(e_mode), .clr_lock(clr_lock),
    .sat_reset(sat_reset), .cp_double(cp_double), .damp_half(damp_half)
  );

  lock_pin_mux u_mux (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
    .wr_test_word(wr_test_word), .test_sel(test_sel), .locked(locked),
    .ref_pulse(ref_pulse), .vco_pulse(vco_pulse), .mod_pulse(mod_pulse),
    .acq_on(acq_on), .div_err(div_err), .lock_out(lock_out)
  );
endmodule

// File: rtl/pullin_lock_chk.sv
module pullin_lock_chk (
  input logic clk,
  input logic rst_n,
  input logic standby,
  input logic wr_div_word,
  input logic f_flag,
  input logic test_mode,
  input logic acq_on,
  input logic e_mode,
  input logic locked,
  input logic lock_hit,
  input logic lock_miss,
  input logic sat_reset,
  input logic cp_double,
  input logic damp_half,
  input logic cp_hiz,
  input logic lock_out
);
  assert_aids_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_on |-> !(sat_reset | cp_double | damp_half));
  assert_sat_damp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_reset | cp_double) |-> damp_half);
  assert_start_ent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_div_word |=> (acq_on == $past(f_flag)));
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_div_word && f_flag) |=> !locked);
  assert_auto_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_on && e_mode && locked && !wr_div_word) |=> !acq_on);
  assert_hit_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_hit && lock_miss));
  assert_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_miss |=> !locked);
  assert_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> (lock_out == locked));
  assert_hiz_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cp_hiz == standby);
  assert_stby_R11: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !locked);
endmodule

bind pullin_lock_ctrl pullin_lock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .wr_div_word(wr_div_word),
  .f_flag(f_flag), .test_mode(test_mode), .acq_on(acq_on), .e_mode(e_mode),
  .locked(locked), .lock_hit(lock_hit), .lock_miss(lock_miss),
  .sat_reset(sat_reset), .cp_double(cp_double), .damp_half(damp_half),
  .cp_hiz(cp_hiz), .lock_out(lock_out)
);

// File: tb/pullin_lock_ctrl_bench.sv
module pullin_lock_ctrl_bench;
  localparam int WIN  = 3;
  localparam int HITS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic standby = 0, wr_ref_word = 0, s_flag = 0, i_flag = 0, e_flag = 0;
  logic wr_div_word = 0, f_flag = 0, test_mode = 0, wr_test_word = 0;
  logic [2:0] test_sel = '0;
  logic ref_pulse = 0, vco_pulse = 0, mod_pulse = 0, div_err = 0;
  logic sat_reset, cp_double, damp_half, cp_hiz, lock_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pullin_lock_ctrl #(.WIN_CYCLES(WIN), .LOCK_HITS(HITS)) u_pullin_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .standby(standby), .wr_ref_word(wr_ref_word),
    .s_flag(s_flag), .i_flag(i_flag), .e_flag(e_flag),
    .wr_div_word(wr_div_word), .f_flag(f_flag), .test_mode(test_mode),
    .wr_test_word(wr_test_word), .test_sel(test_sel),
    .ref_pulse(ref_pulse), .vco_pulse(vco_pulse), .mod_pulse(mod_pulse),
    .div_err(div_err), .sat_reset(sat_reset), .cp_double(cp_double),
    .damp_half(damp_half), .cp_hiz(cp_hiz), .lock_out(lock_out)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic aids(string req, logic s, logic c, logic d);
    chk({req, " sat"}, sat_reset, s);
    chk({req, " cpd"}, cp_double, c);
    chk({req, " damp"}, damp_half, d);
  endtask

  task automatic set_ref_word(logic s, logic i, logic e);
    wr_ref_word = 1; s_flag = s; i_flag = i; e_flag = e; tick();
    wr_ref_word = 0;
  endtask

  task automatic set_start(logic f);
    wr_div_word = 1; f_flag = f; tick();
    wr_div_word = 0; f_flag = 0;
  endtask

  task automatic set_test(logic [2:0] t);
    wr_test_word = 1; test_sel = t; tick();
    wr_test_word = 0; test_sel = '0;
  endtask

  // ref pulse in cycle 0, vco pulse in cycle gap
  task automatic pair(int gap);
    if (gap == 0) begin
      ref_pulse = 1; vco_pulse = 1; tick();
      ref_pulse = 0; vco_pulse = 0;
    end else begin
      ref_pulse = 1; tick(); ref_pulse = 0;
      for (int k = 1; k < gap; k++) tick();
      vco_pulse = 1; tick(); vco_pulse = 0;
    end
  endtask

  task automatic t_reset();
    chk("R12 lock", lock_out, 1'b0);
    chk("R12 hiz", cp_hiz, 1'b0);
    aids("R12", 0, 0, 0);
  endtask

  task automatic t_manual();
    set_ref_word(1, 0, 0);
    set_start(1);
    aids("R1 R4 enter", 1, 0, 1);
    for (int k = 0; k < HITS - 1; k++) pair(0);
    chk("R6 below count", lock_out, 1'b0);
    pair(0);
    chk("R6 at count", lock_out, 1'b1);
    tick(); tick();
    aids("R3 e0 stays", 1, 0, 1);
    set_start(0);
    aids("R1 R5 manual exit", 0, 0, 0);
    chk("R8 lock kept", lock_out, 1'b1);
  endtask

  task automatic t_reentry();
    set_ref_word(0, 1, 1);
    set_start(1);
    chk("R2 clear on re-entry", lock_out, 1'b0);
    aids("R4 R1 re-entry", 0, 1, 1);
    tick();
    aids("R3 no exit unlocked", 0, 1, 1);
  endtask

  task automatic t_auto();
    for (int k = 0; k < HITS; k++) pair(0);
    chk("R3 lock seen", lock_out, 1'b1);
    aids("R5 aids same cycle as lock", 0, 1, 1);
    tick();
    aids("R3 R5 auto exit", 0, 0, 0);
    chk("R8 still locked", lock_out, 1'b1);
  endtask

  task automatic t_window();
    set_ref_word(1, 1, 0);
    set_start(1);
    for (int k = 0; k < HITS; k++) pair(WIN);
    chk("R6 max gap hits", lock_out, 1'b1);
    ref_pulse = 1; tick(); ref_pulse = 0;
    repeat (WIN + 1) tick();
    chk("R7 timeout miss", lock_out, 1'b0);
    for (int k = 0; k < HITS; k++) pair(1);
    chk("R6 relock", lock_out, 1'b1);
    vco_pulse = 1; tick(); vco_pulse = 0; tick();
    vco_pulse = 1; tick(); vco_pulse = 0;
    chk("R7 duplicate miss", lock_out, 1'b0);
    aids("R3 e0 unlocked", 1, 1, 1);
  endtask

  task automatic t_standby();
    for (int k = 0; k < HITS; k++) pair(0);
    chk("R6 pre-standby", lock_out, 1'b1);
    standby = 1; tick();
    chk("R11 hiz", cp_hiz, 1'b1);
    chk("R11 lock cleared", lock_out, 1'b0);
    pair(0); pair(0);
    for (int k = 0; k < HITS; k++) pair(0);
    chk("R11 held clear", lock_out, 1'b0);
    standby = 0; tick();
    chk("R11 hiz off", cp_hiz, 1'b0);
    aids("R11 flags kept", 1, 1, 1);
    set_start(0);
  endtask

  task automatic t_testmux();
    set_test(3'b100);           // normal mode: ignored
    test_mode = 1; tick();
    ref_pulse = 1; #1;
    chk("R10 ignored, rck", lock_out, 1'b1);
    ref_pulse = 0; #1;
    chk("R9 rck low", lock_out, 1'b0);
    set_test(3'b001);
    vco_pulse = 1; #1; chk("R9 vck", lock_out, 1'b1);
    vco_pulse = 0; #1; chk("R9 vck low", lock_out, 1'b0);
    tick();
    set_test(3'b010);
    mod_pulse = 1; #1; chk("R9 mod", lock_out, 1'b1);
    mod_pulse = 0; #1; chk("R9 mod low", lock_out, 1'b0);
    set_test(3'b011);
    chk("R9 acq off", lock_out, 1'b0);
    set_start(1);
    chk("R9 acq on", lock_out, 1'b1);
    set_start(0);
    set_test(3'b111);
    div_err = 1; #1; chk("R9 div_err", lock_out, 1'b1);
    div_err = 0; #1; chk("R9 div_err low", lock_out, 1'b0);
    test_mode = 0; tick();
    test_mode = 1; tick();
    ref_pulse = 1; div_err = 0; #1;
    chk("R10 cleared on exit", lock_out, 1'b1);
    ref_pulse = 0; tick();
    test_mode = 0; tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset();
    t_manual();
    t_reentry();
    t_auto();
    t_window();
    t_standby();
    t_testmux();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule